// File: doc/BRIEF.md
# Barrier Predicate Reduction Unit

This block folds one-bit thread predicates into a per-barrier result while warps gather at a named barrier. Every warp that reaches a barrier with a reduction presents its lane mask of live (non-exited) threads, one predicate bit per lane, an optional complement flag and the operator it wants. The unit accumulates a partial result for that barrier. The operator can be a population count, an all-true test or an any-true test.

The arrival-counting logic elsewhere decides when a barrier is complete and says so on the completion inputs. On that event the unit reports the finished value once, tagged with the barrier index, so that the value can be handed to every warp waiting there. In the same step it empties the accumulator, so the barrier can be used again at once. Warps that only wait or only signal at a barrier are noted but add nothing to the result. A barrier on which such plain arrivals are mixed with reductions raises an error pulse. Reductions on one barrier that disagree on the operator also raise an error pulse.

Top module: `bar_pred_reduce`

## Requirements
- R1: With operator code 0 (count), `res_value` equals the total, over every reduction arrival since the barrier was last cleared, of the lanes whose `arr_active` bit is 1 and whose adjusted predicate is 1. The total is an unsigned 32-bit number.
- R2: With operator code 1 (all-true), `res_value[0]` is 1 exactly when no active lane of any arrival carried an adjusted predicate of 0, so zero active lanes give 1. `res_value[31:1]` is zero.
- R3: With operator code 2 (any-true), `res_value[0]` is 1 exactly when at least one active lane of some arrival carried an adjusted predicate of 1, so zero active lanes give 0. `res_value[31:1]` is zero.
- R4: The adjusted predicate of a lane is `arr_pred` XOR `arr_invert`. Lanes whose `arr_active` bit is 0 never change a result, whatever their predicate.
- R5: Each of the 16 barriers, selected by `arr_bar` and `done_bar`, keeps its own accumulator. Traffic to one barrier never changes the result of another.
- R6: All outputs are low after reset. When `done_valid` is sampled high at a clock edge for a barrier that has had at least one accepted reduction arrival, `res_valid` is high for exactly the following cycle. In that cycle `res_bar` equals `done_bar` and `res_op` equals the barrier's operator. An arrival sampled at the same edge for the same barrier is included in that result.
- R7: A completion clears the barrier's accumulator in the same step. The next arrival starts from empty. A completion for a barrier with no accepted reduction arrival gives no `res_valid` pulse.
- R8: An arrival whose kind (`arr_reduce` = 1 for a reduction, 0 for a plain wait or signal) differs from a kind already recorded on that barrier since its last clear raises `err_mix` for one cycle after the edge. `err_bar` holds that barrier.
- R9: A reduction arrival whose operator differs from the barrier's recorded operator raises `err_op` for one cycle, with `err_bar` set. It is still accumulated, but the barrier keeps the operator of its first reduction arrival.
- R10: A reduction arrival with operator code 3 (reserved) raises `err_op` and is otherwise discarded. It leaves the accumulator and the recorded operator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | A warp arrival is presented this cycle |
| arr_bar | input | 4 | Barrier index of the arrival |
| arr_reduce | input | 1 | 1 = reduction arrival, 0 = plain wait or signal arrival |
| arr_op | input | 2 | Operator: 0 count, 1 all-true, 2 any-true, 3 reserved |
| arr_invert | input | 1 | Complement every lane predicate before combining |
| arr_active | input | 32 | Mask of live lanes in the arriving warp |
| arr_pred | input | 32 | Per-lane predicate bits |
| done_valid | input | 1 | Completion of a barrier, from the arrival tracker |
| done_bar | input | 4 | Index of the completed barrier |
| res_valid | output | 1 | One-cycle pulse: a finished result is presented |
| res_bar | output | 4 | Barrier the result belongs to |
| res_op | output | 2 | Operator the result was formed with |
| res_value | output | 32 | Count, or a single flag in bit 0 |
| err_mix | output | 1 | One-cycle pulse: reduction and plain arrivals mixed on a barrier |
| err_op | output | 1 | One-cycle pulse: operator mismatch or reserved operator |
| err_bar | output | 4 | Barrier index of the last arrival, valid with an error pulse |

## Verification
The hardest case to reach is a completion sampled in the same cycle as the last arrival to the same barrier. In that cycle the folded value must carry that arrival while the register clears. This has to coincide with arrivals and completions on other barriers in the same cycle, and with an error arrival landing on a barrier that is being cleared. Directed sequences drive the coincident arrival-plus-completion on one barrier and on two different barriers. A long random run then confines indices to a few barriers, so that kind and operator collisions, back-to-back completions and reuse right after a clear all occur many times. Each cycle is compared against a behavioural model.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

   localparam int RES_W = 32;

   typedef enum logic [1:0] {
      OP_COUNT = 2'd0,
      OP_ALL   = 2'd1,
      OP_ANY   = 2'd2,
      OP_RSVD  = 2'd3
   } red_op_e;

   typedef struct packed {
      logic             has_red;
      logic             has_plain;
      red_op_e          op;
      logic [RES_W-1:0] cnt;
      logic             all_t;
      logic             any_t;
   } acc_t;

   localparam acc_t ACC_EMPTY = '{
      has_red:   1'b0,
      has_plain: 1'b0,
      op:        OP_COUNT,
      cnt:       '0,
      all_t:     1'b1,
      any_t:     1'b0
   };

endpackage

// File: rtl/bpr_lane_reduce.sv
module bpr_lane_reduce #(
   parameter int LANES = 32,
   parameter int CHUNK = 8,
   localparam int CW   = $clog2(LANES + 1)
) (
   input  logic [LANES-1:0] active_i,
   input  logic [LANES-1:0] pred_i,
   input  logic             invert_i,
   output logic [CW-1:0]    cnt_o,
   output logic             all_o,
   output logic             any_o
);

   logic [LANES-1:0] adj;
   logic [LANES-1:0] live;

   always_comb begin
      adj   = pred_i ^ {LANES{invert_i}};
      live  = active_i & adj;
      all_o = &(adj | ~active_i);
      any_o = |live;
   end

   generate
      if (CHUNK >= 2 && (LANES % CHUNK) == 0 && LANES > CHUNK) begin : g_tree
         localparam int NCH = LANES / CHUNK;
         localparam int PW  = $clog2(CHUNK + 1);

         function automatic logic [PW-1:0] chunk_pop(input logic [CHUNK-1:0] v);
            logic [PW-1:0] s;
            s = '0;
            for (int i = 0; i < CHUNK; i++) begin
               s = s + PW'(v[i]);
            end
            return s;
         endfunction

         logic [NCH*PW-1:0] parts;

         for (genvar g = 0; g < NCH; g++) begin : g_part
            assign parts[g*PW +: PW] = chunk_pop(live[g*CHUNK +: CHUNK]);
         end

         always_comb begin
            cnt_o = '0;
            for (int k = 0; k < NCH; k++) begin
               cnt_o = cnt_o + CW'(parts[k*PW +: PW]);
            end
         end
      end else begin : g_flat
         always_comb begin
            cnt_o = '0;
            for (int i = 0; i < LANES; i++) begin
               cnt_o = cnt_o + CW'(live[i]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bpr_slot.sv
module bpr_slot
   import bpr_pkg::*;
#(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit_i,
   input  logic          clr_i,
   input  logic          red_i,
   input  red_op_e       op_i,
   input  logic [CW-1:0] c_cnt_i,
   input  logic          c_all_i,
   input  logic          c_any_i,
   output acc_t          fold_o,
   output logic          err_mix_o,
   output logic          err_op_o
);

   acc_t q;
   logic op_bad;

   always_comb begin
      fold_o    = q;
      err_mix_o = 1'b0;
      err_op_o  = 1'b0;
      op_bad    = (op_i == OP_RSVD);
      if (hit_i) begin
         if (red_i) begin
            err_mix_o = q.has_plain;
            err_op_o  = op_bad || (q.has_red && (q.op != op_i));
            if (!op_bad) begin
               fold_o.has_red = 1'b1;
               if (!q.has_red) begin
                  fold_o.op = op_i;
               end
               fold_o.cnt   = q.cnt + RES_W'(c_cnt_i);
               fold_o.all_t = q.all_t & c_all_i;
               fold_o.any_t = q.any_t | c_any_i;
            end
         end else begin
            err_mix_o        = q.has_red;
            fold_o.has_plain = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= ACC_EMPTY;
      end else if (clr_i) begin
         q <= ACC_EMPTY;
      end else begin
         q <= fold_o;
      end
   end

   AST_SLOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (q == ACC_EMPTY)) else $error("slot not empty after completion"); // R7

   AST_OP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (q.has_red && !clr_i) |=> (q.op == $past(q.op))) else $error("recorded operator changed"); // R9

   AST_RSVD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i && red_i && op_bad && !clr_i) |=> (q.cnt == $past(q.cnt))) else $error("reserved op accumulated"); // R10

endmodule

// File: rtl/bpr_result.sv
module bpr_result
   import bpr_pkg::*;
#(
   parameter int BAR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_i,
   input  logic [BAR_W-1:0] done_bar_i,
   input  acc_t             sel_i,
   output logic             res_valid_o,
   output logic [BAR_W-1:0] res_bar_o,
   output logic [1:0]       res_op_o,
   output logic [RES_W-1:0] res_value_o
);

   logic [RES_W-1:0] value_d;

   always_comb begin
      unique case (sel_i.op)
         OP_ALL:  value_d = RES_W'(sel_i.all_t);
         OP_ANY:  value_d = RES_W'(sel_i.any_t);
         default: value_d = sel_i.cnt;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid_o <= 1'b0;
         res_bar_o   <= '0;
         res_op_o    <= '0;
         res_value_o <= '0;
      end else begin
         res_valid_o <= done_i && sel_i.has_red;
         if (done_i) begin
            res_bar_o   <= done_bar_i;
            res_op_o    <= sel_i.op;
            res_value_o <= value_d;
         end
      end
   end

   AST_RES_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> ($past(done_i) && res_bar_o == $past(done_bar_i))) else $error("result without completion"); // R6

   AST_FLAG_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_op_o != 2'd0) |-> (res_value_o[RES_W-1:1] == '0)) else $error("flag result too wide"); // R2

endmodule

// File: rtl/bar_pred_reduce.sv
module bar_pred_reduce
   import bpr_pkg::*;
#(
   parameter int LANES    = 32,
   parameter int NUM_BARS = 16,
   parameter int CHUNK    = 8,
   localparam int BAR_W   = $clog2(NUM_BARS),
   localparam int CW      = $clog2(LANES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arr_valid,
   input  logic [BAR_W-1:0] arr_bar,
   input  logic             arr_reduce,
   input  logic [1:0]       arr_op,
   input  logic             arr_invert,
   input  logic [LANES-1:0] arr_active,
   input  logic [LANES-1:0] arr_pred,
   input  logic             done_valid,
   input  logic [BAR_W-1:0] done_bar,
   output logic             res_valid,
   output logic [BAR_W-1:0] res_bar,
   output logic [1:0]       res_op,
   output logic [RES_W-1:0] res_value,
   output logic             err_mix,
   output logic             err_op,
   output logic [BAR_W-1:0] err_bar
);

   generate
      if (LANES < 2) begin : g_chk_lanes
         $error("LANES must be at least 2");
      end
      if (NUM_BARS < 2 || (1 << BAR_W) != NUM_BARS) begin : g_chk_bars
         $error("NUM_BARS must be a power of two of at least 2");
      end
      if (CW > RES_W) begin : g_chk_width
         $error("lane count does not fit the result width");
      end
   endgenerate

   logic [CW-1:0]       lr_cnt;
   logic                lr_all;
   logic                lr_any;
   acc_t                fold     [NUM_BARS];
   logic [NUM_BARS-1:0] hit_vec;
   logic [NUM_BARS-1:0] mix_vec;
   logic [NUM_BARS-1:0] opv_vec;
   acc_t                sel;

   bpr_lane_reduce #(
      .LANES (LANES),
      .CHUNK (CHUNK)
   ) u_lanes (
      .active_i (arr_active),
      .pred_i   (arr_pred),
      .invert_i (arr_invert),
      .cnt_o    (lr_cnt),
      .all_o    (lr_all),
      .any_o    (lr_any)
   );

   generate
      for (genvar b = 0; b < NUM_BARS; b++) begin : g_slot
         assign hit_vec[b] = arr_valid && (arr_bar == BAR_W'(b));

         bpr_slot #(
            .CW (CW)
         ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (hit_vec[b]),
            .clr_i     (done_valid && (done_bar == BAR_W'(b))),
            .red_i     (arr_reduce),
            .op_i      (red_op_e'(arr_op)),
            .c_cnt_i   (lr_cnt),
            .c_all_i   (lr_all),
            .c_any_i   (lr_any),
            .fold_o    (fold[b]),
            .err_mix_o (mix_vec[b]),
            .err_op_o  (opv_vec[b])
         );
      end
   endgenerate

   assign sel = fold[done_bar];

   bpr_result #(
      .BAR_W (BAR_W)
   ) u_result (
      .clk         (clk),
      .rst_n       (rst_n),
      .done_i      (done_valid),
      .done_bar_i  (done_bar),
      .sel_i       (sel),
      .res_valid_o (res_valid),
      .res_bar_o   (res_bar),
      .res_op_o    (res_op),
      .res_value_o (res_value)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_mix <= 1'b0;
         err_op  <= 1'b0;
         err_bar <= '0;
      end else begin
         err_mix <= |mix_vec;
         err_op  <= |opv_vec;
         if (arr_valid) begin
            err_bar <= arr_bar;
         end
      end
   end

   AST_ONE_SLOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)) else $error("arrival reached several slots"); // R5

   AST_ANY_VS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      arr_valid |-> (lr_any == (lr_cnt != '0))) else $error("any-true and count disagree"); // R3

   AST_ERR_NEEDS_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
      (err_mix || err_op) |-> $past(arr_valid)) else $error("error pulse without arrival"); // R8

endmodule

// File: tb/bar_pred_reduce_tb.sv
`timescale 1ns/1ps
module bar_pred_reduce_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        arr_valid, arr_reduce, arr_invert, done_valid;
   logic [3:0]  arr_bar, done_bar;
   logic [1:0]  arr_op;
   logic [31:0] arr_active, arr_pred;
   logic        res_valid, err_mix, err_op;
   logic [3:0]  res_bar, err_bar;
   logic [1:0]  res_op;
   logic [31:0] res_value;

   int vectors = 0;
   int miscompares = 0;

   // behavioural reference state, one entry per barrier
   int m_red   [16];
   int m_plain [16];
   int m_op    [16];
   int m_cnt   [16];
   int m_all   [16];
   int m_any   [16];

   always #2.5 clk = ~clk;

   bar_pred_reduce u_dut (
      .clk (clk), .rst_n (rst_n),
      .arr_valid (arr_valid), .arr_bar (arr_bar), .arr_reduce (arr_reduce),
      .arr_op (arr_op), .arr_invert (arr_invert), .arr_active (arr_active),
      .arr_pred (arr_pred), .done_valid (done_valid), .done_bar (done_bar),
      .res_valid (res_valid), .res_bar (res_bar), .res_op (res_op),
      .res_value (res_value), .err_mix (err_mix), .err_op (err_op),
      .err_bar (err_bar)
   );

   task automatic check(input string tag, input string what, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic model_clear(input int b);
      m_red[b] = 0; m_plain[b] = 0; m_op[b] = 0;
      m_cnt[b] = 0; m_all[b] = 1; m_any[b] = 0;
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic cyc(input logic av, input int bar, input logic red, input int op,
                      input logic inv, input logic [31:0] act, input logic [31:0] pred,
                      input logic dv, input int dbar, input string tag);
      logic [31:0] adj;
      int e_rv, e_rbar, e_rop, e_val, e_mix, e_op, e_ebar;
      arr_valid = av; arr_bar = 4'(bar); arr_reduce = red; arr_op = 2'(op);
      arr_invert = inv; arr_active = act; arr_pred = pred;
      done_valid = dv; done_bar = 4'(dbar);
      @(posedge clk);
      e_rv = 0; e_rbar = 0; e_rop = 0; e_val = 0; e_mix = 0; e_op = 0; e_ebar = bar;
      if (av) begin
         adj = pred ^ {32{inv}};
         if (red) begin
            e_mix = m_plain[bar];
            e_op  = (op == 3 || (m_red[bar] != 0 && m_op[bar] != op)) ? 1 : 0;
            if (op != 3) begin
               if (m_red[bar] == 0) m_op[bar] = op;
               m_red[bar] = 1;
               m_cnt[bar] += $countones(act & adj);
               if ((act & ~adj) != 0) m_all[bar] = 0;
               if ((act & adj) != 0) m_any[bar] = 1;
            end
         end else begin
            e_mix = m_red[bar];
            m_plain[bar] = 1;
         end
      end
      if (dv) begin
         if (m_red[dbar] != 0) begin
            e_rv = 1; e_rbar = dbar; e_rop = m_op[dbar];
            e_val = (m_op[dbar] == 0) ? m_cnt[dbar] :
                    (m_op[dbar] == 1) ? m_all[dbar] : m_any[dbar];
         end
         model_clear(dbar);
      end
      @(negedge clk);
      check({tag, "/R6"}, "res_valid", res_valid, e_rv);
      if (e_rv != 0) begin
         check({tag, "/R6"}, "res_bar", res_bar, e_rbar);
         check({tag, "/R6"}, "res_op", res_op, e_rop);
         check({tag, (e_rop == 0) ? "/R1" : (e_rop == 1) ? "/R2" : "/R3"},
               "res_value", res_value, e_val);
      end
      check({tag, "/R8"}, "err_mix", err_mix, e_mix);
      check({tag, "/R9"}, "err_op", err_op, e_op);
      if (e_mix != 0 || e_op != 0) check({tag, "/R8"}, "err_bar", err_bar, e_ebar);
   endtask

   task automatic idle(input string tag);
      cyc(1'b0, 0, 1'b0, 0, 1'b0, 32'h0, 32'h0, 1'b0, 0, tag);
   endtask

   initial begin
      #1000000;
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      for (int b = 0; b < 16; b++) model_clear(b);
      rst_n = 1'b0;
      arr_valid = 0; arr_bar = 0; arr_reduce = 0; arr_op = 0; arr_invert = 0;
      arr_active = 0; arr_pred = 0; done_valid = 0; done_bar = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R6: reset state
      check("R6", "reset res_valid", res_valid, 0);
      check("R6", "reset err_mix", err_mix, 0);
      check("R6", "reset err_op", err_op, 0);
      check("R6", "reset res_value", res_value, 0);
      rst_n = 1'b1;

      // R1: count over two warps, then completion
      cyc(1, 3, 1, 0, 0, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 0, "R1");
      cyc(1, 3, 1, 0, 0, 32'h0F0F_0F0F, 32'hFFFF_0000, 0, 0, "R1");
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 3, "R1");
      idle("R1");
      // R4: inversion and inactive lanes ignored
      cyc(1, 5, 1, 0, 1, 32'h0000_FFFF, 32'hFFFF_00F0, 0, 0, "R4");
      cyc(1, 5, 1, 0, 0, 32'h0000_0000, 32'hFFFF_FFFF, 1, 5, "R4");
      idle("R4");
      // R2: all-true over zero lanes, then a false lane
      cyc(1, 1, 1, 1, 0, 32'h0, 32'h0, 1, 1, "R2");
      cyc(1, 1, 1, 1, 0, 32'hFF, 32'hFF, 0, 0, "R2");
      cyc(1, 1, 1, 1, 1, 32'h01, 32'h00, 0, 0, "R2");
      cyc(1, 1, 1, 1, 0, 32'h10, 32'h00, 1, 1, "R2");
      // R3: any-true over zero lanes, then one true lane
      cyc(1, 2, 1, 2, 1, 32'h0, 32'h0, 1, 2, "R3");
      cyc(1, 2, 1, 2, 0, 32'hF0, 32'h01, 0, 0, "R3");
      cyc(1, 2, 1, 2, 0, 32'h8000_0000, 32'hFFFF_FFFF, 1, 2, "R3");
      // R5: two barriers interleaved, completion of one alongside arrival at the other
      cyc(1, 7, 1, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R5");
      cyc(1, 8, 1, 2, 0, 32'h1, 32'h0, 0, 0, "R5");
      cyc(1, 8, 1, 2, 0, 32'h2, 32'h0, 1, 7, "R5");
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 8, "R5");
      // R7: plain-only completion gives no pulse; immediate reuse starts empty
      cyc(1, 9, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, "R7");
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 9, "R7");
      cyc(1, 9, 1, 0, 0, 32'h3, 32'h3, 1, 9, "R7");
      cyc(1, 9, 1, 0, 0, 32'h1, 32'h1, 1, 9, "R7");
      // R8: kind mixing in both orders
      cyc(1, 4, 1, 0, 0, 32'h1, 32'h1, 0, 0, "R8");
      cyc(1, 4, 0, 0, 0, 32'h1, 32'h1, 0, 0, "R8");
      cyc(1, 4, 1, 0, 0, 32'h1, 32'h1, 1, 4, "R8");
      // R9: operator mismatch keeps the first operator
      cyc(1, 6, 1, 2, 0, 32'h0, 32'h0, 0, 0, "R9");
      cyc(1, 6, 1, 1, 0, 32'hF, 32'h1, 0, 0, "R9");
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 6, "R9");
      // R10: reserved operator is flagged and dropped
      cyc(1, 10, 1, 3, 0, 32'hFF, 32'hFF, 1, 10, "R10");
      cyc(1, 10, 1, 0, 0, 32'hF, 32'hF, 0, 0, "R10");
      cyc(1, 10, 1, 3, 0, 32'hFF, 32'hFF, 0, 0, "R10");
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 10, "R10");
      idle("R10");

      // R5: random traffic on a few barriers
      for (int n = 0; n < 4000; n++) begin
         int pick;
         pick = $urandom_range(0, 9);
         cyc(($urandom_range(0, 9) < 6), $urandom_range(0, 3),
             ($urandom_range(0, 9) < 8), (pick < 8) ? (pick % 3) : 3,
             1'($urandom_range(0, 1)), $urandom, $urandom,
             ($urandom_range(0, 9) < 2), $urandom_range(0, 3), "R5");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule